// File: doc/BRIEF.md
# Asynchronous Static Memory Sequencer

This block lets a clocked design read and write an external asynchronous static memory of 65,536 sixteen-bit words. A client hands over one word request at a time on a valid/ready handshake, giving the address, a write flag, one enable bit per byte lane and the write data. The block then drives the memory's active-low chip select, output enable, write strobe and per-lane select lines. Read data comes back on a separate port with a one-cycle valid strobe.

All memory timing is met by counting clock cycles. The access time, write-strobe width, data setup and output float time are parameters given in picoseconds together with the clock period. Each phase length is derived from these values, rounding up, with a minimum of one cycle. The data bus is split into an output word, an input word and a drive-enable signal, so the tri-state pad sits outside this block. The sequencer enables its drivers only while the memory's outputs are known to be floating.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request, chip select, output enable, write strobe and both lane selects are high, the bus drivers are off and the response strobe is low.
- R2: During a read, chip select and output enable are low and the write strobe is high. Lane select bit i is the inverse of request enable bit i, and the address and lane selects hold steady for as long as chip select stays low.
- R3: A read keeps chip select low for RD = max(ceil(tAA/T), ceil(tOEA/T), ceil(tRC/T), 1) cycles. The input word is captured on the edge that ends that window, and the response strobe is high for exactly the following cycle.
- R4: Enable bit 0 selects data bits 7:0 and enable bit 1 selects bits 15:8. Any lane not enabled in a read returns zero, whatever the memory presents on it.
- R5: During a write, chip select is low and output enable stays high. The write strobe is low for WP = max(ceil(tWP/T), ceil(tDW/T), ceil(tAW/T), 1) cycles, with lane selects equal to the inverted enables, so only enabled lanes change.
- R6: The write word is driven for the whole write-strobe low time and for one further cycle after the strobe rises.
- R7: The drivers switch on only after output enable has been high for more than FL = ceil(tHZ/T) cycles, and never while output enable is low.
- R8: Request ready is high only while no cycle is in progress, and chip select is high in every such idle cycle.
- R9: A request with both enables clear still runs a memory cycle with both lane selects high. As a write it changes no stored data, and as a read it returns zero.
- R10: Requests issued back to back, each accepted on the first ready cycle, complete in order with correct data.
- R11: The write strobe is low only while chip select is low, and output enable and the write strobe are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | ADDR_W | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | DATA_W/8 | Per-lane enable, bit 0 = bits 7:0 |
| req_wdata | input | DATA_W | Write word |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W | Read word, disabled lanes zero |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_bsel_n | output | DATA_W/8 | Lane selects, active low, bit 0 = bits 7:0 |
| mem_dq_out | output | DATA_W | Word to drive onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus pads |
| mem_dq_in | input | DATA_W | Word sampled from the data bus |

## Verification
The bound checker watches the control lines on every cycle. It checks that the write strobe is low only under chip select and never together with output enable, and that the drivers are never on while output enable is low. It also checks that the drivers start only after output enable has been high, that they are still on when the strobe rises, that address and lane selects hold steady under chip select, and that the response strobe lasts one cycle. Only the bench scenarios can show whether stored data is correct per lane. The same applies to the exact lengths of the access and strobe windows, the length of the float guard after a read, masking of disabled lanes, the effect of an empty enable mask, and in-order completion of back-to-back traffic.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_HOLD
  } seq_state_e;

  // Whole clock cycles covering a delay, never fewer than one.
  function automatic int cycles_for(input int t_ps, input int clk_ps);
    int n;
    n = (t_ps + clk_ps - 1) / clk_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int LANES   = 2,
  parameter int CNT_W   = 2,
  parameter int ACC_CYC = 1,
  parameter int WP_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [LANES-1:0] req_be,
  input  logic             ph_zero,
  input  logic             turn_zero,
  output logic             req_ready,
  output logic             accept,
  output logic             capture,
  output logic             ph_load,
  output logic [CNT_W-1:0] ph_val,
  output logic             turn_load,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] bsel_n,
  output logic             drive
);

  seq_state_e       state_q, state_d;
  logic             ce_q, oe_q, we_q, drv_q;
  logic             ce_d, oe_d, we_d, drv_d;
  logic [LANES-1:0] bsel_q, bsel_d;

  // Next state and phase counter control
  always_comb begin
    state_d   = state_q;
    accept    = 1'b0;
    capture   = 1'b0;
    ph_load   = 1'b0;
    ph_val    = '0;
    turn_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WR_SET;
          end else begin
            state_d = ST_RD_ACC;
            ph_load = 1'b1;
            ph_val  = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_RD_ACC: begin
        if (ph_zero) begin
          capture   = 1'b1;
          turn_load = 1'b1;
          state_d   = ST_IDLE;
        end
      end
      ST_WR_SET: begin
        if (turn_zero) begin
          state_d = ST_WR_PULSE;
          ph_load = 1'b1;
          ph_val  = CNT_W'(WP_CYC - 1);
        end
      end
      ST_WR_PULSE: begin
        if (ph_zero) state_d = ST_WR_HOLD;
      end
      ST_WR_HOLD: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control lines decoded from the next state, registered below
  always_comb begin
    ce_d  = (state_d == ST_IDLE);
    oe_d  = (state_d != ST_RD_ACC);
    we_d  = (state_d != ST_WR_PULSE);
    drv_d = (state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD);
    if (accept) begin
      bsel_d = ~req_be;
    end else if (state_d == ST_IDLE) begin
      bsel_d = '1;
    end else begin
      bsel_d = bsel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      oe_q    <= 1'b1;
      we_q    <= 1'b1;
      drv_q   <= 1'b0;
      bsel_q  <= '1;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      drv_q   <= drv_d;
      bsel_q  <= bsel_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign ce_n      = ce_q;
  assign oe_n      = oe_q;
  assign we_n      = we_q;
  assign bsel_n    = bsel_q;
  assign drive     = drv_q;

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              rvld_q;

  // Disabled lanes read back as zero
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_d[g*LANE_W +: LANE_W] =
      be_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvld_q <= 1'b0;
    end else begin
      rvld_q <= capture;
    end
  end

  assign mem_addr  = addr_q;
  assign dq_out    = wdata_q;
  assign rsp_valid = rvld_q;
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int T_AA_PS       = 15000,
  parameter int T_OEA_PS      = 7000,
  parameter int T_RC_PS       = 15000,
  parameter int T_WP_PS       = 9000,
  parameter int T_AW_PS       = 9000,
  parameter int T_DW_PS       = 7000,
  parameter int T_HZ_PS       = 6000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_write,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_bsel_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int ACC_CYC = max3(cycles_for(T_AA_PS, CLK_PERIOD_PS),
                                cycles_for(T_OEA_PS, CLK_PERIOD_PS),
                                cycles_for(T_RC_PS, CLK_PERIOD_PS));
  localparam int WP_CYC  = max3(cycles_for(T_WP_PS, CLK_PERIOD_PS),
                                cycles_for(T_AW_PS, CLK_PERIOD_PS),
                                cycles_for(T_DW_PS, CLK_PERIOD_PS));
  localparam int FLT_CYC = cycles_for(T_HZ_PS, CLK_PERIOD_PS);
  localparam int PH_MAX  = max3(ACC_CYC, WP_CYC, FLT_CYC);
  localparam int CNT_W   = $clog2(PH_MAX + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  logic             accept, capture;
  logic             ph_load, ph_zero;
  logic [CNT_W-1:0] ph_val;
  logic             turn_load, turn_zero;

  sram_lane_seq #(
    .LANES   (LANES),
    .CNT_W   (CNT_W),
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_be    (req_be),
    .ph_zero   (ph_zero),
    .turn_zero (turn_zero),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ph_load   (ph_load),
    .ph_val    (ph_val),
    .turn_load (turn_load),
    .ce_n      (mem_ce_n),
    .oe_n      (mem_oe_n),
    .we_n      (mem_we_n),
    .bsel_n    (mem_bsel_n),
    .drive     (mem_dq_oe)
  );

  // Phase length counter
  sram_lane_timer #(.W(CNT_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (ph_load),
    .load_val (ph_val),
    .zero     (ph_zero)
  );

  // Bus turnaround guard, started when a read releases output enable
  sram_lane_timer #(.W(CNT_W)) u_turn (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (turn_load),
    .load_val (CNT_W'(FLT_CYC)),
    .zero     (turn_zero)
  );

  sram_lane_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_bsel_n,
  input logic              mem_dq_oe
);

  p_we_under_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_oe_we_apart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_drive_after_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  p_drive_at_strobe_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  p_addr_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_bsel_n)));

  p_idle_deselected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_dq_oe));

  p_rsp_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_ce_n && !mem_oe_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bsel_n (mem_bsel_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;

  localparam int CLK_PS  = 20000;
  localparam int TAA_PS  = 35000;
  localparam int TWP_PS  = 30000;
  localparam int THZ_PS  = 45000;
  // Expected phase lengths worked out from the requirement formulas
  localparam int EXP_RD  = (TAA_PS + CLK_PS - 1) / CLK_PS;  // 2
  localparam int EXP_WP  = (TWP_PS + CLK_PS - 1) / CLK_PS;  // 2
  localparam int EXP_FL  = (THZ_PS + CLK_PS - 1) / CLK_PS;  // 3

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_be;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [15:0] mem_addr, mem_dq_out, mem_dq_in;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_bsel_n;

  always #10 clk = ~clk;

  sram_lane_ctrl #(
    .T_AA_PS (TAA_PS),
    .T_WP_PS (TWP_PS),
    .T_HZ_PS (THZ_PS)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_bsel_n(mem_bsel_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Memory model and independent shadow of expected contents
  logic [15:0] model  [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] mget(input int a);
    return model.exists(a) ? model[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] sget(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [15:0] v;
    if (mem_ce_n === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b0) begin
      v = mget(int'(mem_addr));
      mem_dq_in[7:0]  <= (mem_bsel_n[0] == 1'b0) ? v[7:0]  : 8'hA5;
      mem_dq_in[15:8] <= (mem_bsel_n[1] == 1'b0) ? v[15:8] : 8'hA5;
    end else begin
      mem_dq_in <= 16'h5A5A;
    end
  end

  always @(posedge mem_we_n) begin
    logic [15:0] v;
    if (mem_ce_n === 1'b0) begin
      v = mget(int'(mem_addr));
      if (!mem_bsel_n[0]) v[7:0]  = mem_dq_out[7:0];
      if (!mem_bsel_n[1]) v[15:8] = mem_dq_out[15:8];
      model[int'(mem_addr)] = v;
    end
  end

  // Scoreboard queues
  logic [15:0] exp_data[$];
  logic [1:0]  exp_rbe[$];
  string       exp_tag[$];
  logic [1:0]  exp_wbe[$];

  task automatic issue(input logic [15:0] a, input bit w, input logic [1:0] be,
                       input logic [15:0] d, input string tag);
    logic [15:0] v;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_be = be; req_wdata = d;
    v = sget(int'(a));
    if (w) begin
      if (be[0]) v[7:0]  = d[7:0];
      if (be[1]) v[15:8] = d[15:8];
      shadow[int'(a)] = v;
      exp_wbe.push_back(be);
    end else begin
      exp_data.push_back({be[1] ? v[15:8] : 8'h00, be[0] ? v[7:0] : 8'h00});
      exp_rbe.push_back(be);
      exp_tag.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor
  int         ce_run = 0, ce_last = 0, we_run = 0, oe_hi = 1000;
  bit         dq_prev = 1'b0, oe_low_in_wr = 1'b0, contention = 1'b0;
  bit         busy_ready = 1'b0;
  logic [1:0] rd_bsel = 2'b11;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (mem_ce_n === 1'b0) ce_run++;
      else begin ce_last = ce_run; ce_run = 0; end

      if (mem_oe_n === 1'b1) begin if (oe_hi < 1000) oe_hi++; end
      else oe_hi = 0;

      if (mem_dq_oe && !dq_prev)  // R7 turnaround guard
        chk(oe_hi > EXP_FL, "R7 float guard before drive", oe_hi, EXP_FL + 1);
      dq_prev = mem_dq_oe;

      if (mem_dq_oe && !mem_oe_n) contention = 1'b1;
      if (req_ready && !mem_ce_n) busy_ready = 1'b1;
      if (!mem_ce_n && mem_we_n && !mem_oe_n) rd_bsel = mem_bsel_n;

      if (mem_we_n === 1'b0) begin
        we_run++;
        if (mem_oe_n !== 1'b1 || mem_ce_n !== 1'b0) oe_low_in_wr = 1'b1;
      end else if (we_run != 0) begin
        logic [1:0] wb;
        wb = exp_wbe.size() > 0 ? exp_wbe.pop_front() : 2'bxx;
        chk(we_run == EXP_WP, "R5 strobe width", we_run, EXP_WP);
        chk(mem_dq_oe === 1'b1, "R6 drive held after strobe", mem_dq_oe, 1);
        chk(mem_bsel_n === ~wb, "R5 write lane selects", mem_bsel_n, ~wb);
        we_run = 0;
      end

      if (rsp_valid) begin
        logic [15:0] e;
        logic [1:0]  rb;
        string       t;
        if (exp_data.size() == 0) begin
          chk(1'b0, "R10 unexpected response", rsp_rdata, 0);
        end else begin
          e = exp_data.pop_front(); rb = exp_rbe.pop_front(); t = exp_tag.pop_front();
          chk(rsp_rdata === e, t, rsp_rdata, e);
          chk(ce_last == EXP_RD, "R3 read window length", ce_last, EXP_RD);
          chk(rd_bsel === ~rb, "R2 read lane selects", rd_bsel, ~rb);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk({mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n} === 5'h1F, "R1 controls high in reset",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_bsel_n}, 5'h1F);
    chk(mem_dq_oe === 1'b0 && rsp_valid === 1'b0, "R1 drive and strobe off in reset",
        {mem_dq_oe, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b1 && mem_ce_n === 1'b1, "R8 idle after reset",
        {req_ready, mem_ce_n}, 2'b11);
    chk({mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe} === 5'h1E, "R1 idle controls",
        {mem_oe_n, mem_we_n, mem_bsel_n, mem_dq_oe}, 5'h1E);

    issue(16'h0010, 1, 2'b11, 16'h1234, "");
    issue(16'hFFFF, 1, 2'b11, 16'hBEEF, "");
    issue(16'h0000, 1, 2'b11, 16'hCAFE, "");
    issue(16'h0010, 0, 2'b11, 0, "R3 read word");
    issue(16'hFFFF, 0, 2'b11, 0, "R3 read top address");
    issue(16'h0000, 0, 2'b11, 0, "R3 read address zero");
    issue(16'h0010, 1, 2'b01, 16'hAA55, "");
    issue(16'h0010, 0, 2'b11, 0, "R5 lower lane write only");
    issue(16'h0010, 1, 2'b10, 16'h7700, "");
    issue(16'h0010, 0, 2'b01, 0, "R4 lower lane read");
    issue(16'h0010, 0, 2'b10, 0, "R4 upper lane read");
    issue(16'h0010, 1, 2'b00, 16'hFFFF, "");
    issue(16'h0010, 0, 2'b11, 0, "R9 empty mask write keeps data");
    issue(16'h0010, 0, 2'b00, 0, "R9 empty mask read is zero");
    // Read followed at once by a write exercises the turnaround guard (R7)
    issue(16'h0000, 0, 2'b11, 0, "R7 read before write");
    issue(16'h0020, 1, 2'b11, 16'h0F0F, "");
    issue(16'h0020, 0, 2'b11, 0, "R7 write after read");
    for (int i = 0; i < 8; i++)
      issue(16'h0100 + 16'(i), 1, 2'b11, 16'h3C00 ^ 16'(i * 16'h0111), "");
    for (int i = 0; i < 8; i++)
      issue(16'h0100 + 16'(i), 0, 2'b11, 0, "R10 back to back");

    repeat (20) @(negedge clk);
    chk(exp_data.size() == 0 && exp_wbe.size() == 0, "R10 all requests completed",
        exp_data.size() + exp_wbe.size(), 0);
    chk(!contention, "R7 no drive while output enabled", contention, 0);
    chk(!oe_low_in_wr, "R11 write strobe only under select, output enable high",
        oe_low_in_wr, 0);
    chk(!busy_ready, "R8 chip select high whenever ready", busy_ready, 0);
    summary();
  end

endmodule